// File: doc/BRIEF.md
# Serial Configuration Loader for SRAM-Based Programmable Logic

This block brings up a downstream SRAM-based programmable device through a one-bit serial configuration link. A start pulse sets off a complete sequence. The block pulses an active-low configuration request. It then waits for the target to signal readiness and lets a settling delay pass. Next it pulls configuration bytes from a valid/ready byte stream and shifts each one out least significant bit first. Each bit takes three divider ticks: first the data is presented, then the clock rises, then the clock falls.

After every byte the target status line is sampled. If that line is low, or if the configuration-done line is low after the final byte, the block restarts the whole sequence from the request pulse. The byte source must then resend the stream from its first byte. After the final byte the block issues a fixed burst of trailing clock pulses and leaves the clock high. It then requires init-done before it reports success. A retry counter gives up after a set number of failed attempts and raises an error flag.

Every pin change happens on a tick from a system-clock divider. This keeps the serial clock within the target's rate limit.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, cfg_req_n is 1, cfg_dclk, cfg_data, in_ready, busy, done and error are 0.
- R2: On the first tick after start is seen while idle, busy rises and cfg_req_n, cfg_dclk and cfg_data all go low. cfg_req_n stays low for exactly REQ_TICKS ticks and is then released high.
- R3: After the release, the block checks tgt_status on each tick. The tick on which it reads 1 begins a delay of DELAY_TICKS ticks. Only after that delay does in_ready rise.
- R4: in_ready is high only while the block waits for a byte. A byte, together with its in_last flag, is taken on any clock where in_valid and in_ready are both high. in_valid held low stalls the load with no pin activity.
- R5: Each byte goes out bit 0 first. For each bit, cfg_data takes the bit value on one tick, cfg_dclk rises on the next tick, and it falls on the tick after that. A byte therefore takes 24 ticks.
- R6: On the tick after a byte's final clock fall, tgt_status is sampled. If it is 0, the attempt fails and the sequence restarts, with cfg_req_n going low on that same tick.
- R7: After the byte marked last, if tgt_conf_done is 0 at the same sampling tick, the attempt fails and restarts.
- R8: After a good last byte, cfg_dclk toggles on each of 2*TRAIL_PULSES+1 ticks. This gives TRAIL_PULSES full pulses and then leaves the clock high. A successful load shows 8*bytes+TRAIL_PULSES+1 rising edges in all.
- R9: On the tick after the trailing clocks, if tgt_init_done is 1, done goes high and busy goes low. Otherwise the attempt fails. done and error clear when the next sequence begins.
- R10: A failed attempt restarts the sequence unless it is attempt number MAX_TRIES. In that case error goes high, busy goes low and done stays 0.
- R11: Ticks occur every DIV system clocks from reset. Outputs cfg_req_n, cfg_dclk and cfg_data change only on clock edges where a tick is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration sequence (seen while idle) |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | Current byte is the final one of the bitstream |
| in_ready | output | 1 | Block is waiting for a byte |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| cfg_dclk | output | 1 | Serial configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| tgt_status | input | 1 | Target status, high when healthy/ready |
| tgt_conf_done | input | 1 | Target reports bitstream received |
| tgt_init_done | input | 1 | Target reports initialization complete |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Last sequence succeeded |
| error | output | 1 | Last sequence gave up after MAX_TRIES attempts |

## Verification
The hardest case to reach is a restart that starts partway through a byte stream. The target has to drop its status between a byte's final clock rise and the following sampling tick. The source then has to rewind and resend exactly the same stream. The bench reaches this by watching the serial clock edges it receives. It pulls tgt_status low on a chosen rising edge, restores it on the next request pulse, and rewinds its source queue on that same pulse. A behavioural tick-counting model then follows the restart on every clock. Configuration-done failures and init-done failures are set up the same way, keyed to the attempt number, and a persistent init-done failure drives the retry count to its limit.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DELAY,
    ST_FETCH,
    ST_SHIFT,
    ST_CHECK,
    ST_TRAIL,
    ST_FINAL
  } ld_state_t;

  // bits needed to hold values 0..maxval
  function automatic int ps_cnt_bits(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  function automatic int ps_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // number of clock toggles in the trailing burst, minus one (counter load)
  function automatic int ps_trail_load(input int pulses);
    return 2 * pulses;
  endfunction

endpackage

// File: rtl/ps_cfg_tick.sv
module ps_cfg_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import ps_cfg_pkg::*;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = ps_cnt_bits(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
    end
  endgenerate

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] byte_in,
  input  logic         step,
  output logic         bit_val,
  output logic         ev_data,
  output logic         ev_rise,
  output logic         ev_fall,
  output logic         byte_end
);
  import ps_cfg_pkg::*;
  localparam int IW = ps_cnt_bits(W - 1);

  logic [W-1:0]  sr;
  logic [IW-1:0] idx;
  logic [1:0]    ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      idx <= '0;
      ph  <= 2'd0;
    end else if (load) begin
      sr  <= byte_in;
      idx <= '0;
      ph  <= 2'd0;
    end else if (step) begin
      case (ph)
        2'd0:    ph <= 2'd1;
        2'd1:    ph <= 2'd2;
        default: begin
          ph  <= 2'd0;
          sr  <= {1'b0, sr[W-1:1]};
          idx <= idx + 1'b1;
        end
      endcase
    end
  end

  assign bit_val  = sr[0];
  assign ev_data  = step && (ph == 2'd0);
  assign ev_rise  = step && (ph == 2'd1);
  assign ev_fall  = step && (ph == 2'd2);
  assign byte_end = ev_fall && (idx == IW'(W - 1));

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (ph == 2'd0)); // R4
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ph != 2'd3); // R5

endmodule

// File: rtl/ps_cfg_retry.sv
module ps_cfg_retry #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last_try
);
  import ps_cfg_pkg::*;
  localparam int TW = ps_cnt_bits(MAX_TRIES);

  logic [TW-1:0] tries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tries <= '0;
    else if (clr)   tries <= '0;
    else if (bump)  tries <= tries + 1'b1;
  end

  assign last_try = (tries == TW'(MAX_TRIES - 1));

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(MAX_TRIES)); // R10
  AST_NO_BUMP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !last_try); // R10

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int DIV          = 4,
  parameter int REQ_TICKS    = 3,
  parameter int DELAY_TICKS  = 255,
  parameter int TRAIL_PULSES = 45,
  parameter int MAX_TRIES    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_req_n,
  output logic       cfg_dclk,
  output logic       cfg_data,
  input  logic       tgt_status,
  input  logic       tgt_conf_done,
  input  logic       tgt_init_done,
  output logic       busy,
  output logic       done,
  output logic       error
);
  import ps_cfg_pkg::*;

  localparam int TRAIL_LOAD = ps_trail_load(TRAIL_PULSES);
  localparam int CNT_MAX    = ps_max(ps_max(REQ_TICKS, DELAY_TICKS), TRAIL_LOAD);
  localparam int CW         = ps_cnt_bits(CNT_MAX);

  ld_state_t     state;
  logic [CW-1:0] cnt;
  logic          pend, last_q;
  logic          req_n_q, dclk_q, dat_q, done_q, err_q;

  // named internal events
  logic tick, seq_go, byte_take, fail_ev, last_try, restart;
  logic sh_step, sh_bit, ev_data, ev_rise, ev_fall, byte_end;

  ps_cfg_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign in_ready  = (state == ST_FETCH);
  assign byte_take = in_ready && in_valid;
  assign sh_step   = tick && (state == ST_SHIFT);
  assign seq_go    = tick && pend && (state == ST_IDLE);
  assign fail_ev   = tick && (((state == ST_CHECK) && (!tgt_status || (last_q && !tgt_conf_done)))
                           || ((state == ST_FINAL) && !tgt_init_done));
  assign restart   = seq_go || (fail_ev && !last_try);

  ps_cfg_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(byte_take), .byte_in(in_data), .step(sh_step),
    .bit_val(sh_bit), .ev_data(ev_data), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .byte_end(byte_end)
  );

  ps_cfg_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(seq_go), .bump(fail_ev && !last_try),
    .last_try(last_try)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pend    <= 1'b0;
      last_q  <= 1'b0;
      req_n_q <= 1'b1;
      dclk_q  <= 1'b0;
      dat_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start && state == ST_IDLE) pend <= 1'b1;
      if (seq_go) begin
        pend   <= 1'b0;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (restart) begin
        state   <= ST_REQ;
        req_n_q <= 1'b0;
        dclk_q  <= 1'b0;
        dat_q   <= 1'b0;
        cnt     <= CW'(REQ_TICKS - 1);
      end else if (fail_ev) begin
        state <= ST_IDLE;
        err_q <= 1'b1;
      end else begin
        case (state)
          ST_REQ: if (tick) begin
            if (cnt == '0) begin
              req_n_q <= 1'b1;
              state   <= ST_WAIT;
            end else cnt <= cnt - 1'b1;
          end
          ST_WAIT: if (tick && tgt_status) begin
            state <= ST_DELAY;
            cnt   <= CW'(DELAY_TICKS - 1);
          end
          ST_DELAY: if (tick) begin
            if (cnt == '0) state <= ST_FETCH;
            else           cnt   <= cnt - 1'b1;
          end
          ST_FETCH: if (byte_take) begin
            last_q <= in_last;
            state  <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (ev_data) dat_q  <= sh_bit;
            if (ev_rise) dclk_q <= 1'b1;
            if (ev_fall) dclk_q <= 1'b0;
            if (byte_end) state <= ST_CHECK;
          end
          ST_CHECK: if (tick) begin
            if (last_q) begin
              state <= ST_TRAIL;
              cnt   <= CW'(TRAIL_LOAD);
            end else state <= ST_FETCH;
          end
          ST_TRAIL: if (tick) begin
            dclk_q <= ~dclk_q;
            if (cnt == '0) state <= ST_FINAL;
            else           cnt   <= cnt - 1'b1;
          end
          ST_FINAL: if (tick) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign cfg_req_n = req_n_q;
  assign cfg_dclk  = dclk_q;
  assign cfg_data  = dat_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cfg_req_n); // R2
  AST_CLK_LOW_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !cfg_dclk); // R2
  AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cfg_req_n && !cfg_dclk && busy)); // R4
  AST_DATA_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_dclk) |-> $stable(cfg_data)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R10
  AST_PINS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cfg_dclk) && $stable(cfg_req_n) && $stable(cfg_data))); // R11

endmodule

// File: tb/tb_ps_cfg_loader.sv
module tb_ps_cfg_loader;
  localparam int DIV = 4, REQ = 3, DLY = 255, TRL = 45, MAXT = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] in_data;
  logic in_valid, in_last, in_ready, cfg_req_n, cfg_dclk, cfg_data;
  logic tgt_status = 1'b1, tgt_conf_done = 1'b1, tgt_init_done = 1'b1;
  logic busy, done, error;

  always #2 clk = ~clk; // 250 MHz

  ps_cfg_loader #(.DIV(DIV), .REQ_TICKS(REQ), .DELAY_TICKS(DLY),
                  .TRAIL_PULSES(TRL), .MAX_TRIES(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_req_n(cfg_req_n), .cfg_dclk(cfg_dclk),
    .cfg_data(cfg_data), .tgt_status(tgt_status), .tgt_conf_done(tgt_conf_done),
    .tgt_init_done(tgt_init_done), .busy(busy), .done(done), .error(error));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- byte source ----------------
  logic [7:0] src[$];
  int idx = 0;
  bit gaps = 0, took = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (in_valid && in_ready) took = 1;
  end
  always @(negedge clk) begin
    if (took) begin idx++; took = 0; end
    in_valid = (idx < src.size()) && (!gaps || (cyc % 3 == 0));
    in_data  = (idx < src.size()) ? src[idx] : 8'h00;
    in_last  = (idx == src.size() - 1);
  end

  // ---------------- target side ----------------
  int rises = 0, attempts = 0, drop_at = 0, cd_ok_at = 1, id_ok_at = 1;
  bit restore_status = 0;
  logic [7:0] cur = 8'h00;
  logic [7:0] got[$];
  always @(posedge cfg_dclk) begin
    cur[rises % 8] = cfg_data;
    rises++;
    if (rises % 8 == 0) got.push_back(cur);
    if (drop_at > 0 && rises == drop_at) begin tgt_status = 1'b0; drop_at = 0; end
  end
  always @(negedge cfg_req_n) begin
    rises = 0; got.delete(); attempts++; idx = 0; took = 0;
    if (restore_status) tgt_status = 1'b1;
    tgt_conf_done = (attempts >= cd_ok_at);
    tgt_init_done = (attempts >= id_ok_at);
  end

  // ---------------- behavioural reference ----------------
  // modes: 0 idle, 1 request, 2 wait ready, 3 delay, 4 fetch, 5 shift, 6 check, 7 trail, 8 final
  int m_div = 0, m_mode = 0, m_cnt = 0, m_sub = 0, m_fails = 0;
  bit m_pend = 0, m_last = 0, m_req = 1, m_clk = 0, m_dat = 0, m_done = 0, m_err = 0;
  logic [7:0] m_byte = 8'h00;
  bit started = 0;

  task automatic m_restart();
    m_mode = 1; m_cnt = 0; m_req = 0; m_clk = 0; m_dat = 0;
  endtask
  task automatic m_failed();
    if (m_fails + 1 == MAXT) begin m_mode = 0; m_err = 1; end
    else begin m_fails++; m_restart(); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_mode = 0; m_pend = 0; m_req = 1; m_clk = 0; m_dat = 0;
      m_done = 0; m_err = 0; m_fails = 0;
    end else begin
      bit tk, oldp;
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      case (m_mode)
        0: begin
          oldp = m_pend;
          if (start) m_pend = 1;
          if (tk && oldp) begin
            m_pend = 0; m_done = 0; m_err = 0; m_fails = 0; m_restart();
          end
        end
        1: if (tk) begin m_cnt++; if (m_cnt == REQ) begin m_req = 1; m_mode = 2; end end
        2: if (tk && tgt_status) begin m_mode = 3; m_cnt = 0; end
        3: if (tk) begin m_cnt++; if (m_cnt == DLY) m_mode = 4; end
        4: if (in_valid) begin m_byte = in_data; m_last = in_last; m_sub = 0; m_mode = 5; end
        5: if (tk) begin
          case (m_sub % 3)
            0: m_dat = m_byte[m_sub / 3];
            1: m_clk = 1;
            default: m_clk = 0;
          endcase
          if (m_sub == 23) m_mode = 6;
          m_sub++;
        end
        6: if (tk) begin
          if (!tgt_status || (m_last && !tgt_conf_done)) m_failed();
          else if (m_last) begin m_mode = 7; m_cnt = 0; end
          else m_mode = 4;
        end
        7: if (tk) begin m_clk = !m_clk; m_cnt++; if (m_cnt == 2 * TRL + 1) m_mode = 8; end
        default: if (tk) begin
          if (!tgt_init_done) m_failed();
          else begin m_mode = 0; m_done = 1; end
        end
      endcase
    end
    started = 1;
  end

  always @(negedge clk) if (started) begin
    chk(cfg_req_n == m_req, "R2 cfg_req_n", cfg_req_n, m_req);
    chk(cfg_dclk == m_clk, "R5/R8/R11 cfg_dclk", cfg_dclk, m_clk);
    chk(cfg_data == m_dat, "R5 cfg_data", cfg_data, m_dat);
    chk(in_ready == (m_mode == 4), "R3/R4 in_ready", in_ready, m_mode == 4);
    chk(busy == (m_mode != 0), "R1 busy", busy, m_mode != 0);
    chk(done == m_done, "R9 done", done, m_done);
    chk(error == m_err, "R10 error", error, m_err);
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic run_load();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (DIV + 2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    chk(got.size() >= src.size(), req, got.size(), src.size());
    foreach (src[k]) if (k < got.size()) chk(got[k] == src[k], "R5 byte LSB first", got[k], src[k]);
    chk(rises == 8 * src.size() + TRL + 1, "R8 rising edges", rises, 8 * src.size() + TRL + 1);
  endtask

  initial begin
    in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cfg_req_n == 1'b1 && cfg_dclk == 1'b0 && cfg_data == 1'b0, "R1 pins", {cfg_req_n, cfg_dclk, cfg_data}, 3'b100);
    chk(!busy && !done && !error && !in_ready, "R1 status", {busy, done, error, in_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // normal load
    src = '{8'hA5, 8'h3C, 8'h81};
    attempts = 0; run_load();
    chk(done && !error, "R9 success", {done, error}, 2'b10);
    chk(attempts == 1, "R2 one attempt", attempts, 1);
    check_stream("R5 normal count");

    // late ready with stalling source
    src = '{8'h01, 8'hFE, 8'h5A, 8'h7F};
    gaps = 1; tgt_status = 1'b0; attempts = 0;
    fork
      run_load();
      begin repeat (60) @(negedge clk); tgt_status = 1'b1; end
    join
    gaps = 0;
    chk(done, "R3 late ready done", done, 1);
    check_stream("R4 stalled count");

    // status drop after second byte
    src = '{8'h11, 8'h22, 8'h33};
    attempts = 0; restore_status = 1; drop_at = 16;
    run_load();
    restore_status = 0;
    chk(attempts == 2, "R6 restart attempts", attempts, 2);
    chk(done && !error, "R6 recovered", {done, error}, 2'b10);
    check_stream("R6 resend count");

    // conf_done low on first attempt
    src = '{8'hC3, 8'h96};
    attempts = 0; cd_ok_at = 2;
    run_load();
    cd_ok_at = 1;
    chk(attempts == 2, "R7 restart attempts", attempts, 2);
    chk(done, "R7 recovered", done, 1);
    check_stream("R7 resend count");

    // init_done never high -> give up
    src = '{8'hE7};
    attempts = 0; id_ok_at = 99;
    run_load();
    chk(attempts == MAXT, "R10 attempts", attempts, MAXT);
    chk(error && !done && !busy, "R10 error flag", {error, done, busy}, 3'b100);
    chk(cfg_dclk == 1'b1, "R8 clock left high", cfg_dclk, 1);

    // next start clears error
    id_ok_at = 1; attempts = 0;
    run_load();
    chk(done && !error, "R9 flags cleared", {done, error}, 2'b10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule